// File: doc/BRIEF.md
# I2C Controller Interrupt and Status Flag Unit

This block keeps the interrupt-related status of an I2C controller that can act as bus master or slave. A byte-level shift engine beside it reports events as single-cycle strobes: the first bit of an outgoing byte leaving the shifter, a complete incoming byte, and whether that byte was an address. From these the unit keeps three interrupt flags: transmit register empty, receive register full and slave address matched. It also keeps two informational bits, general-address hit and direction, which software reads to tell a read from a write and a general call from a START byte.

All three flags feed one level-sensitive interrupt request. Software finds the cause by reading a status word. It clears the flags as a side effect of normal work: writing the transmit data register, reading the receive data register, or reading the status word. The receive path has no FIFO. Its only back-pressure is a hold request to the bus engine, which keeps SCL low during the final bit of the next incoming byte while the previous byte is still unread. The engine treats `scl_hold` as a "not ready" and must not finish that byte while it is high. Register accesses are modelled as one-cycle strobes.

Status word layout: bit 7 transmit-empty, bit 6 receive-full, bit 5 address-match, bit 4 general-address hit, bit 3 direction (received address bit 0), bits 2..0 read as zero. All flag updates are registered: an event at a clock edge shows in the status word, `irq` and `scl_hold` right after that edge.

Top module: `i2c_irq_status`

## Requirements
- R1: `irq` is high exactly when the unit is enabled and at least one of these holds: transmit-empty set with the transmit interrupt enable high, receive-full set, or address-match set. It stays high while any of these causes persists.
- R2: Transmit-empty (bit 7) sets when `tx_first_bit` pulses with `tx_kind` 0 (first byte of a 10-bit address), with `tx_kind` 1 (last address byte) while `tx_rw` is 0, or with `tx_kind` 2 (data byte). It does not set for `tx_kind` 1 with `tx_rw` 1, and it does not set for `tx_kind` 3.
- R3: A `sw_wr_data` strobe always clears transmit-empty, even when a setting event arrives in the same cycle. `tx_data` then holds the written byte.
- R4: With `ctl_tx_ien` low, transmit-empty still shows in bit 7 but does not raise `irq`.
- R5: A receive byte that qualifies sets receive-full (bit 6) and is loaded into `rx_data`. A `sw_rd_data` strobe clears receive-full, unless a qualifying byte arrives in the same cycle. In master mode every received byte qualifies.
- R6: In slave mode with interactive receive off, an address byte never sets receive-full. A data byte sets it only if the last address byte matched. Bytes that do not qualify leave `rx_data` unchanged.
- R7: In slave mode with interactive receive on, every received address and data byte sets receive-full.
- R8: In slave mode, an address byte whose upper seven bits equal `ctl_own_addr` sets address-match (bit 5) and copies its bit 0 into the direction bit (bit 3). A `sw_rd_stat` strobe clears address-match unless a new match arrives in the same cycle.
- R9: Address bytes 0x00 (general call) and 0x01 (START byte) match only while `ctl_gcall_en` is high. Such a match sets bit 4, and the direction bit (0 or 1) tells the two apart. A unique match that is not one of these two addresses clears bit 4.
- R10: `scl_hold` is high exactly when the unit is enabled, the engine signals the final bit of an incoming byte (`rx_last_bit`), and receive-full is still set.
- R11: After reset, and one cycle after `ctl_enable` is low, bits 7..3 of the status word are zero. While `ctl_enable` is low, `irq` and `scl_hold` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enable; low clears all flags |
| ctl_slave | input | 1 | 1 = slave mode, 0 = master mode |
| ctl_tx_ien | input | 1 | Transmit interrupt enable |
| ctl_irm | input | 1 | Interactive receive mode |
| ctl_gcall_en | input | 1 | Recognize general-call and START-byte addresses |
| ctl_own_addr | input | 7 | Unique slave address |
| tx_first_bit | input | 1 | Strobe: first bit of an outgoing byte shifted out |
| tx_kind | input | 2 | Kind of that byte: 0 ten-bit first, 1 last address, 2 data, 3 other |
| tx_rw | input | 1 | Read bit carried by the outgoing last address byte |
| rx_byte_valid | input | 1 | Strobe: a complete byte was received |
| rx_byte_is_addr | input | 1 | The received byte is an address byte |
| rx_byte_data | input | 8 | Received byte |
| rx_last_bit | input | 1 | Engine is at the final data bit of an incoming byte |
| sw_rd_stat | input | 1 | Strobe: software reads the status word |
| sw_rd_data | input | 1 | Strobe: software reads the receive data register |
| sw_wr_data | input | 1 | Strobe: software writes the transmit data register |
| sw_wdata | input | 8 | Byte written by software |
| stat | output | 8 | Status word |
| rx_data | output | 8 | Receive data register |
| tx_data | output | 8 | Transmit data register, to the shift engine |
| irq | output | 1 | Level interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
A flag stuck in the wrong state shows up in the status word and on `irq` in the cycle right after the event that should have changed it. Every flag is one register deep, so no wrong value can stay hidden over several cycles. A wrong match state in slave mode is only latent until the next data byte. That byte then sets or fails to set receive-full one cycle later, and at a final bit `scl_hold` shows the same error at once. The bench therefore compares every output on every cycle against a model built from the requirements.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int BYTE_W  = 8;
  localparam int SADDR_W = BYTE_W - 1;
  localparam int STAT_W  = 8;

  // status word bit positions (software decodes these)
  localparam int ST_TDRE = STAT_W - 1;
  localparam int ST_RDRF = STAT_W - 2;
  localparam int ST_SAM  = STAT_W - 3;
  localparam int ST_GCA  = STAT_W - 4;
  localparam int ST_DIR  = STAT_W - 5;

  localparam logic [BYTE_W-1:0] GCALL_CODE = '0;
  localparam logic [BYTE_W-1:0] SBYTE_CODE = BYTE_W'(1);

  typedef enum logic [1:0] {
    TXK_TEN_FIRST = 2'b00,
    TXK_ADDR_LAST = 2'b01,
    TXK_DATA      = 2'b10,
    TXK_OTHER     = 2'b11
  } tx_kind_e;

  function automatic logic is_general_code(input logic [BYTE_W-1:0] b);
    return (b == GCALL_CODE) || (b == SBYTE_CODE);
  endfunction
endpackage

// File: rtl/i2c_txe_flag.sv
module i2c_txe_flag
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              shift_first,
  input  logic [1:0]        kind,
  input  logic              rw_bit,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wdata,
  output logic              tdre,
  output logic [BYTE_W-1:0] tx_byte
);
  logic qual;

  always_comb begin
    unique case (tx_kind_e'(kind))
      TXK_TEN_FIRST: qual = 1'b1;
      TXK_ADDR_LAST: qual = ~rw_bit;
      TXK_DATA:      qual = 1'b1;
      default:       qual = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  tdre <= 1'b0;
    else if (!en)                tdre <= 1'b0;
    else if (wr_stb)             tdre <= 1'b0;
    else if (shift_first && qual) tdre <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_byte <= '0;
    else if (wr_stb) tx_byte <= wdata;
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               slave,
  input  logic               gce,
  input  logic [SADDR_W-1:0] own_addr,
  input  logic               rx_valid,
  input  logic               rx_is_addr,
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic               stat_rd,
  output logic               sam,
  output logic               gca,
  output logic               dir,
  output logic               hit
);
  logic addr_ev, uni, gen, match;

  assign addr_ev = en && slave && rx_valid && rx_is_addr;
  assign uni     = (rx_byte[BYTE_W-1:1] == own_addr);
  assign gen     = gce && is_general_code(rx_byte);
  assign match   = uni || gen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sam <= 1'b0; gca <= 1'b0; dir <= 1'b0; hit <= 1'b0;
    end else if (!en) begin
      sam <= 1'b0; gca <= 1'b0; dir <= 1'b0; hit <= 1'b0;
    end else begin
      if (addr_ev) hit <= match;
      if (addr_ev && match) begin
        sam <= 1'b1;
        gca <= gen;
        dir <= rx_byte[0];
      end else if (stat_rd) begin
        sam <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_rxf_flag.sv
module i2c_rxf_flag
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              slave,
  input  logic              irm,
  input  logic              hit,
  input  logic              rx_valid,
  input  logic              rx_is_addr,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rd_stb,
  output logic              rdrf,
  output logic [BYTE_W-1:0] rdata
);
  logic qual, take;

  // slave without interactive mode: only data after a matched address
  assign qual = !slave || irm || (!rx_is_addr && hit);
  assign take = en && rx_valid && qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdrf <= 1'b0;
    else if (!en)    rdrf <= 1'b0;
    else if (take)   rdrf <= 1'b1;
    else if (rd_stb) rdrf <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (take) rdata <= rx_byte;
  end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_enable,
  input  logic               ctl_slave,
  input  logic               ctl_tx_ien,
  input  logic               ctl_irm,
  input  logic               ctl_gcall_en,
  input  logic [SADDR_W-1:0] ctl_own_addr,
  input  logic               tx_first_bit,
  input  logic [1:0]         tx_kind,
  input  logic               tx_rw,
  input  logic               rx_byte_valid,
  input  logic               rx_byte_is_addr,
  input  logic [BYTE_W-1:0]  rx_byte_data,
  input  logic               rx_last_bit,
  input  logic               sw_rd_stat,
  input  logic               sw_rd_data,
  input  logic               sw_wr_data,
  input  logic [BYTE_W-1:0]  sw_wdata,
  output logic [STAT_W-1:0]  stat,
  output logic [BYTE_W-1:0]  rx_data,
  output logic [BYTE_W-1:0]  tx_data,
  output logic               irq,
  output logic               scl_hold
);
  logic tdre, rdrf, sam, gca, dir, hit;

  i2c_txe_flag u_txe (
    .clk(clk), .rst_n(rst_n), .en(ctl_enable),
    .shift_first(tx_first_bit), .kind(tx_kind), .rw_bit(tx_rw),
    .wr_stb(sw_wr_data), .wdata(sw_wdata),
    .tdre(tdre), .tx_byte(tx_data)
  );

  i2c_addr_match u_match (
    .clk(clk), .rst_n(rst_n), .en(ctl_enable), .slave(ctl_slave),
    .gce(ctl_gcall_en), .own_addr(ctl_own_addr),
    .rx_valid(rx_byte_valid), .rx_is_addr(rx_byte_is_addr),
    .rx_byte(rx_byte_data), .stat_rd(sw_rd_stat),
    .sam(sam), .gca(gca), .dir(dir), .hit(hit)
  );

  i2c_rxf_flag u_rxf (
    .clk(clk), .rst_n(rst_n), .en(ctl_enable), .slave(ctl_slave),
    .irm(ctl_irm), .hit(hit),
    .rx_valid(rx_byte_valid), .rx_is_addr(rx_byte_is_addr),
    .rx_byte(rx_byte_data), .rd_stb(sw_rd_data),
    .rdrf(rdrf), .rdata(rx_data)
  );

  always_comb begin
    stat          = '0;
    stat[ST_TDRE] = tdre;
    stat[ST_RDRF] = rdrf;
    stat[ST_SAM]  = sam;
    stat[ST_GCA]  = gca;
    stat[ST_DIR]  = dir;
  end

  assign irq      = ctl_enable && ((tdre && ctl_tx_ien) || rdrf || sam);
  assign scl_hold = ctl_enable && rx_last_bit && rdrf;
endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk
  import i2c_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_enable,
  input logic              rx_byte_valid,
  input logic              rx_last_bit,
  input logic              sw_rd_stat,
  input logic              sw_rd_data,
  input logic              sw_wr_data,
  input logic [STAT_W-1:0] stat,
  input logic              irq,
  input logic              scl_hold
);
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> (stat[ST_TDRE:ST_DIR] == '0)); // R11
  AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |-> !irq); // R11
  AST_WR_CLEARS_TDRE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_data |=> !stat[ST_TDRE]); // R3
  AST_RD_CLEARS_RDRF: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_data && !rx_byte_valid) |=> !stat[ST_RDRF]); // R5
  AST_STAT_CLEARS_SAM: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd_stat && !rx_byte_valid) |=> !stat[ST_SAM]); // R8
  AST_RDRF_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_RDRF]) |-> $past(rx_byte_valid)); // R6
  AST_HOLD_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> (stat[ST_RDRF] && rx_last_bit)); // R10
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat[ST_TDRE] || stat[ST_RDRF] || stat[ST_SAM])); // R1
endmodule

bind i2c_irq_status i2c_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable),
  .rx_byte_valid(rx_byte_valid), .rx_last_bit(rx_last_bit),
  .sw_rd_stat(sw_rd_stat), .sw_rd_data(sw_rd_data), .sw_wr_data(sw_wr_data),
  .stat(stat), .irq(irq), .scl_hold(scl_hold)
);

// File: tb/test_i2c_irq_status.sv
`timescale 1ns/1ps
module test_i2c_irq_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, slv = 0, ien = 0, irm = 0, gce = 0;
  logic [6:0] own = 7'h2A;
  logic txf = 0, txrw = 0, rxv = 0, rxa = 0, rxl = 0, rds = 0, rdd = 0, wrd = 0;
  logic [1:0] txk = 2'd3;
  logic [7:0] rxb = 0, wdat = 0;
  logic [7:0] stat, rx_data, tx_data;
  logic irq, scl_hold;
  int total = 0, bad = 0;
  // model state
  logic m_tdre = 0, m_rdrf = 0, m_sam = 0, m_gca = 0, m_dir = 0, m_hit = 0;
  logic [7:0] m_rdata = 0, m_txb = 0;

  always #10 clk = ~clk; // 50 MHz

  i2c_irq_status i_i2c_irq_status (
    .clk(clk), .rst_n(rst_n), .ctl_enable(en), .ctl_slave(slv), .ctl_tx_ien(ien),
    .ctl_irm(irm), .ctl_gcall_en(gce), .ctl_own_addr(own),
    .tx_first_bit(txf), .tx_kind(txk), .tx_rw(txrw),
    .rx_byte_valid(rxv), .rx_byte_is_addr(rxa), .rx_byte_data(rxb), .rx_last_bit(rxl),
    .sw_rd_stat(rds), .sw_rd_data(rdd), .sw_wr_data(wrd), .sw_wdata(wdat),
    .stat(stat), .rx_data(rx_data), .tx_data(tx_data), .irq(irq), .scl_hold(scl_hold)
  );

  function automatic logic tx_sets(input logic [1:0] k, input logic rw);
    return (k == 2'd0) || (k == 2'd1 && !rw) || (k == 2'd2);
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "stat", stat, {m_tdre, m_rdrf, m_sam, m_gca, m_dir, 3'b000});
    chk(req, "irq", {7'd0, irq}, {7'd0, en && ((m_tdre && ien) || m_rdrf || m_sam)});
    chk(req, "scl_hold", {7'd0, scl_hold}, {7'd0, en && rxl && m_rdrf});
    chk(req, "rx_data", rx_data, m_rdata);
    chk(req, "tx_data", tx_data, m_txb);
  endtask

  // one clock: compute expected next state from requirements, then compare
  task automatic cyc(input string req);
    logic n_tdre, n_rdrf, n_sam, n_gca, n_dir, n_hit, uni, gen, q;
    logic [7:0] n_rdata;
    n_tdre = m_tdre; n_rdrf = m_rdrf; n_sam = m_sam; n_gca = m_gca;
    n_dir = m_dir; n_hit = m_hit; n_rdata = m_rdata;
    if (!en) begin
      n_tdre = 0; n_rdrf = 0; n_sam = 0; n_gca = 0; n_dir = 0; n_hit = 0;
    end else begin
      if (wrd) n_tdre = 0; else if (txf && tx_sets(txk, txrw)) n_tdre = 1;     // R2 R3
      uni = (rxb[7:1] == own);
      gen = gce && (rxb == 8'h00 || rxb == 8'h01);                              // R9
      if (slv && rxv && rxa) begin
        n_hit = uni || gen;
        if (uni || gen) begin n_sam = 1; n_gca = gen; n_dir = rxb[0]; end       // R8
        else if (rds) n_sam = 0;
      end else if (rds) n_sam = 0;
      q = !slv || irm || (!rxa && m_hit);                                       // R6 R7
      if (rxv && q) begin n_rdrf = 1; n_rdata = rxb; end
      else if (rdd) n_rdrf = 0;                                                 // R5
    end
    @(posedge clk); #2;
    m_tdre = n_tdre; m_rdrf = n_rdrf; m_sam = n_sam; m_gca = n_gca;
    m_dir = n_dir; m_hit = n_hit; m_rdata = n_rdata;
    if (wrd) m_txb = wdat;
    compare(req);
    @(negedge clk);
  endtask

  task automatic idle();
    txf = 0; rxv = 0; rds = 0; rdd = 0; wrd = 0; rxl = 0;
  endtask

  task automatic rx_byte(input logic a, input logic [7:0] b, input string req);
    rxv = 1; rxa = a; rxb = b; cyc(req); idle();
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R11");                    // reset state
    rst_n = 1; en = 1; ien = 1;
    cyc("R11");
    // R2: last address byte with read bit does not set transmit-empty
    txf = 1; txk = 2'd1; txrw = 1; cyc("R2"); idle();
    txf = 1; txk = 2'd3; cyc("R2"); idle();
    txf = 1; txk = 2'd1; txrw = 0; cyc("R2"); idle();
    // R3: write clears, wins over simultaneous set
    txf = 1; txk = 2'd2; wrd = 1; wdat = 8'hC3; cyc("R3"); idle();
    txf = 1; txk = 2'd0; cyc("R2"); idle();
    // R4: enable off masks irq
    ien = 0; cyc("R4"); ien = 1; wrd = 1; wdat = 8'h5A; cyc("R3"); idle();
    // R5 master receive, read race
    slv = 0; rx_byte(0, 8'h77, "R5");
    rxl = 1; cyc("R10"); idle();
    rdd = 1; rxv = 1; rxa = 0; rxb = 8'h78; cyc("R5"); idle();
    rdd = 1; cyc("R5"); idle();
    // R6 slave, no IRM, non-match then data
    slv = 1; irm = 0; gce = 0;
    rx_byte(1, 8'h12, "R6"); rx_byte(0, 8'h99, "R6");
    rx_byte(1, {own, 1'b1}, "R8"); rx_byte(0, 8'h3C, "R6");
    rds = 1; rdd = 1; cyc("R8"); idle();
    // R9 general call off then on
    rx_byte(1, 8'h00, "R9");
    gce = 1; rx_byte(1, 8'h00, "R9"); rds = 1; cyc("R9"); idle();
    rx_byte(1, 8'h01, "R9"); rx_byte(1, {own, 1'b0}, "R9");
    // R7 interactive receive
    irm = 1; rds = 1; cyc("R8"); idle();
    rx_byte(1, 8'hF0, "R7"); rdd = 1; cyc("R7"); idle();
    rx_byte(0, 8'h0F, "R7");
    // R11 disable clears
    en = 0; rxl = 1; cyc("R11"); cyc("R11"); idle(); en = 1; cyc("R11");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      en   = ($urandom % 40) != 0;
      if ($urandom % 50 == 0) begin
        slv = $urandom; irm = $urandom; gce = $urandom; ien = $urandom;
      end
      txf  = ($urandom % 4) == 0; txk = $urandom; txrw = $urandom;
      wrd  = ($urandom % 8) == 0; wdat = $urandom;
      rds  = ($urandom % 6) == 0; rdd = ($urandom % 6) == 0;
      rxv  = ($urandom % 4) == 0; rxa = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: rxb = {own, 1'($urandom)};
        1: rxb = 8'h00;
        2: rxb = 8'h01;
        default: rxb = $urandom;
      endcase
      rxl  = ($urandom % 3) == 0;
      cyc("R1");
    end
    idle(); cyc("R1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule